// File: doc/BRIEF.md
# Serial Controller Host Register File with Interrupt Prioritizer

This block is the host-facing register set of a 16550-style serial controller. A host reaches it through an asynchronous bus made of an active-low chip select, separate active-low read and write strobes, a 3-bit register select and 8-bit data buses in each direction, plus an output enable for a shared tri-state bus. The block holds the interrupt enable, line control, modem control and FIFO control settings and a 16-bit baud divisor. It passes these settings to the shifter, FIFO and baud logic around it, and it receives status levels and event pulses back from that logic.

The strobes are brought into the system clock domain, and every access becomes one single-cycle pulse. As a result, each read side effect happens exactly once, however long the strobe is held. The top bit of the line control register switches what offsets 0 and 1 reach. Pending interrupt sources are ranked into a 4-bit identification code, and one active-high interrupt line is driven from them. Each source has its own clearing action.

Top module: `sercfg_regfile`

## Requirements
- R1: After reset the interrupt output is low, both modem handshake outputs are high, the output enable is low, the divisor and every control field are zero, and offset 2 reads 0x01.
- R2: With line control bit 7 set, offset 0 and offset 1 read and write the divisor low and high bytes. With bit 7 clear, offset 0 pushes transmit data on write (a one-cycle `tx_push` with `tx_data`) and returns `rx_data` on read, and offset 1 is interrupt enable.
- R3: A write to offset 2 sets the FIFO fields: bit 0 FIFO enable, bit 1 a one-cycle receive clear pulse, bit 2 a one-cycle transmit clear pulse, bit 3 ready-pin mode, bits 7:6 trigger select. Offset 3 is line control, driving word length (1:0), long stop (2), parity enable (3), even parity (4), stick parity (5) and break (6).
- R4: Offset 2 reads the highest pending enabled source as 0x06 line status, 0x04 received data, 0x0C character timeout, 0x02 transmit holding empty, 0x00 modem status, or 0x01 when none is pending, ranked in that order.
- R5: Interrupt enable bit 0 gates received data and timeout, bit 1 transmit empty, bit 2 line status and bit 3 modem status. `irq` is high exactly when some enabled source is pending.
- R6: Offset 5 reads {0, tx_idle, thr_empty, break, framing, parity, overrun, rx_ready} from bit 7 down. The four error bits latch their event pulses and clear when offset 5 is read.
- R7: A read of offset 0 with bit 7 of line control clear issues exactly one `rx_pop` pulse.
- R8: A transmit-empty interrupt is raised by a rising `thr_empty`. It clears on a transmit data write, or on an offset 2 read that returns 0x02.
- R9: Offset 6 reads the complements of carrier detect, ring, data set ready and clear to send in bits 7 to 4. Bits 3, 1 and 0 latch any change on carrier detect, data set ready and clear to send. Bit 2 latches only a low-to-high change of `ri_n`. All four change bits clear when offset 6 is read.
- R10: Modem control bits 0 and 1 drive `dtr_n` and `rts_n` inverted. Modem control bits 7:2 and interrupt enable bits 7:4 read as 0 whatever was written.
- R11: A write to either divisor byte updates `divisor` and issues a single-cycle `div_load` pulse.
- R12: A strobe held low for many cycles acts once. A modem change that arrives while an offset 6 read strobe is still low is kept for the next read.
- R13: Strobes given while `sel_n` is high change no register and do not raise the output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register select |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data, held from the access pulse |
| dout_en | output | 1 | Drive enable for a shared data bus |
| rx_data | input | 8 | Head of receive FIFO |
| rx_ready | input | 1 | Receive FIFO holds data |
| rx_trig | input | 1 | Received data pending (trigger reached) |
| rx_tmo | input | 1 | Character timeout pending |
| err_overrun | input | 1 | Overrun event pulse |
| err_parity | input | 1 | Parity error event pulse |
| err_framing | input | 1 | Framing error event pulse |
| err_break | input | 1 | Break event pulse |
| thr_empty | input | 1 | Transmit holding empty level |
| tx_idle | input | 1 | Transmitter fully idle |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| ri_n | input | 1 | Ring, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| irq | output | 1 | Interrupt request, active high |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| tx_data | output | 8 | Last transmit data written |
| tx_push | output | 1 | Transmit data write pulse |
| rx_pop | output | 1 | Receive data read pulse |
| word_len | output | 2 | Character length code |
| stop_long | output | 1 | Long stop select |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity select |
| par_stick | output | 1 | Stick parity select |
| brk_ctl | output | 1 | Force break |
| fifo_en | output | 1 | FIFO enable |
| rdy_mode | output | 1 | Ready-pin mode |
| trig_sel | output | 2 | Receive trigger select |
| tx_clr | output | 1 | Transmit FIFO clear pulse |
| rx_clr | output | 1 | Receive FIFO clear pulse |
| divisor | output | 16 | Baud divisor |
| div_load | output | 1 | Divisor reload pulse |

## Verification
The bench builds the block with its default of two synchronizer stages. Each strobe is held low for four or five clocks, and successive accesses are spaced well beyond four clocks, so every access produces exactly one internal pulse. With this spacing the bench can hold a strobe far longer than the synchronizer depth, which exercises the act-once rule and the case of a modem change arriving in the middle of a read. The stimulus raises every interrupt source at once, then removes them one clearing action at a time, so each step of the ranking is observed through offset 2.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int DW = 8;
  localparam int NSRC = 5;
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_IER  = 3'd1;
  localparam logic [2:0] A_IID  = 3'd2;
  localparam logic [2:0] A_LCR  = 3'd3;
  localparam logic [2:0] A_MCR  = 3'd4;
  localparam logic [2:0] A_LSR  = 3'd5;
  localparam logic [2:0] A_MSR  = 3'd6;

  typedef enum logic [3:0] {
    IID_MDM  = 4'b0000,
    IID_NONE = 4'b0001,
    IID_THRE = 4'b0010,
    IID_RXD  = 4'b0100,
    IID_LINE = 4'b0110,
    IID_TMO  = 4'b1100
  } iid_e;

  // source index 0 is the highest priority
  function automatic iid_e src_code(input int idx);
    case (idx)
      0:       return IID_LINE;
      1:       return IID_RXD;
      2:       return IID_TMO;
      3:       return IID_THRE;
      default: return IID_MDM;
    endcase
  endfunction
endpackage

// File: rtl/sercfg_strobe_sync.sv
module sercfg_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_pulse,
  output logic wr_pulse,
  output logic rd_hold
);
  localparam int CW = 3 * STAGES;

  logic [CW-1:0] chain_q;
  logic [2:0]    sync_w;
  logic          rd_lvl, wr_lvl, rd_prev_q, wr_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q   <= '1;
      rd_prev_q <= 1'b0;
      wr_prev_q <= 1'b0;
    end else begin
      chain_q   <= {chain_q[CW-4:0], sel_n, rd_n, wr_n};
      rd_prev_q <= rd_lvl;
      wr_prev_q <= wr_lvl;
    end
  end

  always_comb begin
    sync_w   = chain_q[CW-1 -: 3];
    rd_lvl   = !sync_w[2] && !sync_w[1];
    wr_lvl   = !sync_w[2] && !sync_w[0];
    rd_pulse = rd_lvl && !rd_prev_q;
    wr_pulse = wr_lvl && !wr_prev_q;
    rd_hold  = rd_lvl;
  end

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |=> !rd_pulse); // R12
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse); // R12
endmodule

// File: rtl/sercfg_modem_stat.sv
module sercfg_modem_stat #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] lines_n,   // {dcd, ri, dsr, cts}
  input  logic       clr,
  output logic [7:0] msr
);
  localparam int CW = 4 * STAGES;

  logic [CW-1:0] chain_q;
  logic [3:0]    now_w, prev_q, delta_q, delta_d, set_w;

  always_comb begin
    now_w   = chain_q[CW-1 -: 4];
    set_w   = {now_w[3] ^ prev_q[3],
               now_w[2] && !prev_q[2],
               now_w[1] ^ prev_q[1],
               now_w[0] ^ prev_q[0]};
    delta_d = (clr ? 4'b0 : delta_q) | set_w;
    msr     = {~now_w, delta_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 4'hF;
      delta_q <= 4'h0;
    end else begin
      chain_q <= {chain_q[CW-5:0], lines_n};
      prev_q  <= now_w;
      delta_q <= delta_d;
    end
  end

  AST_DELTA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_w == 4'b0) |=> delta_q == 4'b0); // R9
  AST_RING_FALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!now_w[2] && prev_q[2] && !delta_q[2]) |=> !delta_q[2]); // R9
endmodule

// File: rtl/sercfg_irq_prio.sv
module sercfg_irq_prio
  import sercfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] en,
  output iid_e            iid,
  output logic            irq
);
  logic [NSRC-1:0] act, grant;
  logic            found;
  iid_e            iid_d;

  always_comb begin
    act   = pend & en;
    grant = '0;
    found = 1'b0;
    iid_d = IID_NONE;
    for (int i = 0; i < NSRC; i++) begin
      if (act[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
        iid_d    = src_code(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iid <= IID_NONE;
      irq <= 1'b0;
    end else begin
      iid <= iid_d;
      irq <= found;
    end
  end

  AST_GRANT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R4
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|act) |=> irq); // R5
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |=> (!irq && iid == IID_NONE)); // R5
endmodule

// File: rtl/sercfg_regfile.sv
module sercfg_regfile
  import sercfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic [2:0]  addr,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  output logic        dout_en,
  input  logic [7:0]  rx_data,
  input  logic        rx_ready,
  input  logic        rx_trig,
  input  logic        rx_tmo,
  input  logic        err_overrun,
  input  logic        err_parity,
  input  logic        err_framing,
  input  logic        err_break,
  input  logic        thr_empty,
  input  logic        tx_idle,
  input  logic        cts_n,
  input  logic        dsr_n,
  input  logic        ri_n,
  input  logic        dcd_n,
  output logic        irq,
  output logic        dtr_n,
  output logic        rts_n,
  output logic [7:0]  tx_data,
  output logic        tx_push,
  output logic        rx_pop,
  output logic [1:0]  word_len,
  output logic        stop_long,
  output logic        par_en,
  output logic        par_even,
  output logic        par_stick,
  output logic        brk_ctl,
  output logic        fifo_en,
  output logic        rdy_mode,
  output logic [1:0]  trig_sel,
  output logic        tx_clr,
  output logic        rx_clr,
  output logic [15:0] divisor,
  output logic        div_load
);
  localparam int DIVW = 2 * DW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  logic rd_pulse, wr_pulse, rd_hold;
  sercfg_strobe_sync #(.STAGES(SYNC_STAGES)) u_strobe (
    .clk(clk), .rst_n(rst_ni), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .rd_pulse(rd_pulse), .wr_pulse(wr_pulse), .rd_hold(rd_hold)
  );

  // state
  logic [3:0]    ier_q;
  logic [7:0]    lcr_q;
  logic [1:0]    mcr_q;
  logic          fifo_en_q, rdy_mode_q;
  logic [1:0]    trig_q;
  logic [DW-1:0] dll_q, dlm_q, tx_data_q, dout_q;
  logic [3:0]    lsr_err_q, lsr_err_d;   // {break, framing, parity, overrun}
  logic          thre_pend_q, thre_pend_d, thr_prev_q;
  logic          tx_push_q, rx_pop_q, div_load_q, tx_clr_q, rx_clr_q;

  // decode
  logic dlab, wr_dll, wr_dlm, wr_thr, wr_ier, wr_fcr, wr_lcr, wr_mcr;
  logic rd_rbr, rd_lsr, rd_msr, rd_iid, thr_rise;
  logic [7:0] msr_w, lsr_w, rd_mux;
  logic [NSRC-1:0] src_pend, src_en;
  iid_e iid_w;

  sercfg_modem_stat #(.STAGES(SYNC_STAGES)) u_modem (
    .clk(clk), .rst_n(rst_ni), .lines_n({dcd_n, ri_n, dsr_n, cts_n}),
    .clr(rd_msr), .msr(msr_w)
  );

  always_comb begin
    dlab   = lcr_q[7];
    wr_dll = wr_pulse &&  dlab && (addr == A_DATA);
    wr_dlm = wr_pulse &&  dlab && (addr == A_IER);
    wr_thr = wr_pulse && !dlab && (addr == A_DATA);
    wr_ier = wr_pulse && !dlab && (addr == A_IER);
    wr_fcr = wr_pulse && (addr == A_IID);
    wr_lcr = wr_pulse && (addr == A_LCR);
    wr_mcr = wr_pulse && (addr == A_MCR);
    rd_rbr = rd_pulse && !dlab && (addr == A_DATA);
    rd_iid = rd_pulse && (addr == A_IID);
    rd_lsr = rd_pulse && (addr == A_LSR);
    rd_msr = rd_pulse && (addr == A_MSR);

    thr_rise    = thr_empty && !thr_prev_q;
    lsr_err_d   = (rd_lsr ? 4'b0 : lsr_err_q)
                | {err_break, err_framing, err_parity, err_overrun};
    thre_pend_d = thr_rise
                || (thre_pend_q && !(wr_thr || (rd_iid && iid_w == IID_THRE)));

    lsr_w = {1'b0, tx_idle, thr_empty, lsr_err_q, rx_ready};

    case (addr)
      A_DATA:  rd_mux = dlab ? dll_q : rx_data;
      A_IER:   rd_mux = dlab ? dlm_q : {4'b0, ier_q};
      A_IID:   rd_mux = {4'b0, iid_w};
      A_LCR:   rd_mux = lcr_q;
      A_MCR:   rd_mux = {6'b0, mcr_q};
      A_LSR:   rd_mux = lsr_w;
      A_MSR:   rd_mux = msr_w;
      default: rd_mux = 8'h00;
    endcase

    // sources ranked: line, rx data, timeout, tx empty, modem
    src_pend = {|msr_w[3:0], thre_pend_q, rx_tmo, rx_trig, |lsr_err_q};
    src_en   = {ier_q[3], ier_q[1], ier_q[0], ier_q[0], ier_q[2]};
  end

  sercfg_irq_prio u_prio (
    .clk(clk), .rst_n(rst_ni), .pend(src_pend), .en(src_en),
    .iid(iid_w), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q       <= '0;
      lcr_q       <= '0;
      mcr_q       <= '0;
      fifo_en_q   <= 1'b0;
      rdy_mode_q  <= 1'b0;
      trig_q      <= '0;
      dll_q       <= '0;
      dlm_q       <= '0;
      tx_data_q   <= '0;
      dout_q      <= '0;
      lsr_err_q   <= '0;
      thre_pend_q <= 1'b0;
      thr_prev_q  <= 1'b0;
      tx_push_q   <= 1'b0;
      rx_pop_q    <= 1'b0;
      div_load_q  <= 1'b0;
      tx_clr_q    <= 1'b0;
      rx_clr_q    <= 1'b0;
    end else begin
      if (wr_ier) ier_q <= din[3:0];
      if (wr_lcr) lcr_q <= din;
      if (wr_mcr) mcr_q <= din[1:0];
      if (wr_fcr) begin
        fifo_en_q  <= din[0];
        rdy_mode_q <= din[3];
        trig_q     <= din[7:6];
      end
      if (wr_dll) dll_q <= din;
      if (wr_dlm) dlm_q <= din;
      if (wr_thr) tx_data_q <= din;
      if (rd_pulse) dout_q <= rd_mux;
      lsr_err_q   <= lsr_err_d;
      thre_pend_q <= thre_pend_d;
      thr_prev_q  <= thr_empty;
      tx_push_q   <= wr_thr;
      rx_pop_q    <= rd_rbr;
      div_load_q  <= wr_dll || wr_dlm;
      tx_clr_q    <= wr_fcr && din[2];
      rx_clr_q    <= wr_fcr && din[1];
    end
  end

  assign dout      = dout_q;
  assign dout_en   = rd_hold;
  assign dtr_n     = !mcr_q[0];
  assign rts_n     = !mcr_q[1];
  assign tx_data   = tx_data_q;
  assign tx_push   = tx_push_q;
  assign rx_pop    = rx_pop_q;
  assign word_len  = lcr_q[1:0];
  assign stop_long = lcr_q[2];
  assign par_en    = lcr_q[3];
  assign par_even  = lcr_q[4];
  assign par_stick = lcr_q[5];
  assign brk_ctl   = lcr_q[6];
  assign fifo_en   = fifo_en_q;
  assign rdy_mode  = rdy_mode_q;
  assign trig_sel  = trig_q;
  assign tx_clr    = tx_clr_q;
  assign rx_clr    = rx_clr_q;
  assign divisor   = DIVW'({dlm_q, dll_q});
  assign div_load  = div_load_q;

  AST_DTR_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_mcr |=> (dtr_n == !$past(din[0]) && rts_n == !$past(din[1]))); // R10
  AST_LSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_lsr && !err_break && !err_framing && !err_parity && !err_overrun)
    |=> lsr_err_q == 4'b0); // R6
  AST_DIV_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    div_load |=> !div_load); // R11
  AST_THRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_thr && !thr_rise) |=> !thre_pend_q); // R8
  AST_POP_ONCE: assert property (@(posedge clk) disable iff (!rst_ni)
    rx_pop |=> !rx_pop); // R7
endmodule

// File: tb/sercfg_regfile_bench.sv
module sercfg_regfile_bench;
  logic clk = 1'b0;
  always #2 clk = !clk;   // 250 MHz

  logic rst_n, sel_n, rd_n, wr_n;
  logic [2:0] addr;
  logic [7:0] din, rx_data;
  logic rx_ready, rx_trig, rx_tmo, err_overrun, err_parity, err_framing, err_break;
  logic thr_empty, tx_idle, cts_n, dsr_n, ri_n, dcd_n;
  logic [7:0] dout, tx_data;
  logic dout_en, irq, dtr_n, rts_n, tx_push, rx_pop;
  logic [1:0] word_len, trig_sel;
  logic stop_long, par_en, par_even, par_stick, brk_ctl, fifo_en, rdy_mode, tx_clr, rx_clr;
  logic [15:0] divisor;
  logic div_load;

  sercfg_regfile u_sercfg_regfile (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_trig(rx_trig), .rx_tmo(rx_tmo),
    .err_overrun(err_overrun), .err_parity(err_parity),
    .err_framing(err_framing), .err_break(err_break),
    .thr_empty(thr_empty), .tx_idle(tx_idle),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .irq(irq), .dtr_n(dtr_n), .rts_n(rts_n),
    .tx_data(tx_data), .tx_push(tx_push), .rx_pop(rx_pop),
    .word_len(word_len), .stop_long(stop_long), .par_en(par_en),
    .par_even(par_even), .par_stick(par_stick), .brk_ctl(brk_ctl),
    .fifo_en(fifo_en), .rdy_mode(rdy_mode), .trig_sel(trig_sel),
    .tx_clr(tx_clr), .rx_clr(rx_clr), .divisor(divisor), .div_load(div_load)
  );

  int checks = 0, errors = 0;
  int n_push = 0, n_pop = 0, n_div = 0, n_txclr = 0, n_rxclr = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (tx_push)  n_push++;
    if (rx_pop)   n_pop++;
    if (div_load) n_div++;
    if (tx_clr)   n_txclr++;
    if (rx_clr)   n_rxclr++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; sel_n = 1'b0;
    idle(1); wr_n = 1'b0;
    idle(4); wr_n = 1'b1;
    idle(1); sel_n = 1'b1;
    idle(4);
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; sel_n = 1'b0;
    idle(1); rd_n = 1'b0;
    idle(5); v = dout;
    rd_n = 1'b1;
    idle(1); sel_n = 1'b1;
    idle(4);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq", int'(irq), 0);
    chk("R1 dtr_n", int'(dtr_n), 1);
    chk("R1 rts_n", int'(rts_n), 1);
    chk("R1 dout_en idle", int'(dout_en), 0);
    chk("R1 divisor", int'(divisor), 0);
    chk("R1 fifo_en", int'(fifo_en), 0);
    chk("R1 word_len", int'(word_len), 0);
    @(negedge clk); addr = 3'd2; sel_n = 1'b0;
    idle(1); rd_n = 1'b0;
    idle(5);
    chk("R1 dout_en during read", int'(dout_en), 1);
    chk("R1 iid none", int'(dout), 'h01);
    rd_n = 1'b1; idle(1); sel_n = 1'b1; idle(4);
    chk("R1 dout_en after read", int'(dout_en), 0);
    reg_read(3'd3, v);
    chk("R1 line control zero", int'(v), 0);
  endtask

  task automatic t_bank();
    logic [7:0] v;
    reg_write(3'd3, 8'h80);
    reg_write(3'd0, 8'h78);
    reg_write(3'd1, 8'h01);
    chk("R11 divisor", int'(divisor), 'h0178);
    chk("R11 div_load pulses", n_div, 2);
    reg_read(3'd0, v); chk("R2 divisor low read", int'(v), 'h78);
    reg_read(3'd1, v); chk("R2 divisor high read", int'(v), 'h01);
    chk("R2 no push in bank 1", n_push, 0);
    chk("R7 no pop in bank 1", n_pop, 0);
    reg_write(3'd3, 8'h3B);
    reg_read(3'd3, v); chk("R3 line control read", int'(v), 'h3B);
    chk("R3 word_len", int'(word_len), 3);
    chk("R3 stop/parity/brk", int'({brk_ctl, par_stick, par_even, par_en, stop_long}), 'b01110);
    reg_write(3'd0, 8'h5A);
    chk("R2 tx push", n_push, 1);
    chk("R2 tx data", int'(tx_data), 'h5A);
    rx_data = 8'hC3;
    reg_read(3'd0, v);
    chk("R2 rx data read", int'(v), 'hC3);
    chk("R7 one pop", n_pop, 1);
    reg_write(3'd1, 8'hFF);
    reg_read(3'd1, v); chk("R10 ier upper bits zero", int'(v), 'h0F);
    reg_write(3'd1, 8'h00);
    chk("R11 divisor kept in bank 0", int'(divisor), 'h0178);
  endtask

  task automatic t_fifo_mcr();
    logic [7:0] v;
    reg_write(3'd2, 8'hC7);
    chk("R3 fifo_en", int'(fifo_en), 1);
    chk("R3 trig_sel", int'(trig_sel), 3);
    chk("R3 rdy_mode", int'(rdy_mode), 0);
    chk("R3 clear pulses", n_txclr * 16 + n_rxclr, 'h11);
    reg_write(3'd2, 8'h08);
    chk("R3 fifo fields second", int'({fifo_en, rdy_mode, trig_sel}), 'b0100);
    chk("R3 no extra clears", n_txclr + n_rxclr, 2);
    reg_write(3'd4, 8'hFF);
    chk("R10 dtr/rts low", int'({dtr_n, rts_n}), 0);
    reg_read(3'd4, v); chk("R10 mcr upper zero", int'(v), 'h03);
    reg_write(3'd4, 8'h02);
    chk("R10 dtr high rts low", int'({dtr_n, rts_n}), 'b10);
  endtask

  task automatic t_lsr();
    logic [7:0] v;
    @(negedge clk); err_parity = 1'b1;
    @(negedge clk); err_parity = 1'b0;
    @(negedge clk); err_overrun = 1'b1;
    @(negedge clk); err_overrun = 1'b0;
    idle(2);
    reg_read(3'd5, v); chk("R6 lsr errors latched", int'(v), 'h06);
    reg_read(3'd5, v); chk("R6 lsr cleared by read", int'(v), 'h00);
  endtask

  task automatic t_prio();
    logic [7:0] v;
    thr_empty = 1'b1; rx_ready = 1'b1; rx_trig = 1'b1; rx_tmo = 1'b1; cts_n = 1'b0;
    @(negedge clk); err_framing = 1'b1;
    @(negedge clk); err_framing = 1'b0;
    idle(6);
    chk("R5 irq low with all disabled", int'(irq), 0);
    reg_read(3'd2, v); chk("R5 iid none when disabled", int'(v), 'h01);
    reg_write(3'd1, 8'h0F);
    chk("R5 irq raised", int'(irq), 1);
    reg_read(3'd2, v); chk("R4 line status first", int'(v), 'h06);
    reg_read(3'd5, v); chk("R6 lsr view", int'(v), 'h29);
    reg_read(3'd2, v); chk("R4 rx data second", int'(v), 'h04);
    rx_trig = 1'b0; idle(3);
    reg_read(3'd2, v); chk("R4 timeout third", int'(v), 'h0C);
    rx_tmo = 1'b0; idle(3);
    reg_read(3'd2, v); chk("R8 tx empty shown", int'(v), 'h02);
    reg_read(3'd2, v); chk("R8 cleared by iid read, modem next", int'(v), 'h00);
    reg_read(3'd6, v); chk("R9 msr cts low delta", int'(v), 'h11);
    reg_read(3'd2, v); chk("R4 none after all cleared", int'(v), 'h01);
    chk("R5 irq dropped", int'(irq), 0);
    reg_write(3'd1, 8'h08);
    cts_n = 1'b1; idle(6);
    chk("R5 modem enable raises irq", int'(irq), 1);
    reg_write(3'd1, 8'h00);
    chk("R5 disable drops irq", int'(irq), 0);
    reg_read(3'd6, v); chk("R9 msr cts high delta", int'(v), 'h01);
    rx_ready = 1'b0;
  endtask

  task automatic t_thre();
    logic [7:0] v;
    thr_empty = 1'b0; idle(3);
    reg_write(3'd1, 8'h02);
    chk("R8 nothing pending yet", int'(irq), 0);
    thr_empty = 1'b1; idle(3);
    chk("R8 rise raises irq", int'(irq), 1);
    reg_write(3'd0, 8'h11);
    chk("R8 thr write clears", int'(irq), 0);
    reg_read(3'd2, v); chk("R8 iid none after write", int'(v), 'h01);
    reg_write(3'd1, 8'h00);
  endtask

  task automatic t_modem();
    logic [7:0] v;
    ri_n = 1'b0; idle(6);
    reg_read(3'd6, v); chk("R9 ring falling no delta", int'(v), 'h40);
    ri_n = 1'b1; idle(6);
    reg_read(3'd6, v); chk("R9 ring trailing edge", int'(v), 'h04);
    dcd_n = 1'b0; dsr_n = 1'b0; idle(6);
    reg_read(3'd6, v); chk("R9 dcd dsr deltas", int'(v), 'hAA);
    reg_read(3'd6, v); chk("R9 deltas cleared", int'(v), 'hA0);
    dcd_n = 1'b1; dsr_n = 1'b1; idle(6);
    reg_read(3'd6, v); chk("R9 release deltas", int'(v), 'h0A);
  endtask

  task automatic t_once();
    logic [7:0] v;
    int pops;
    pops = n_pop;
    @(negedge clk); addr = 3'd0; sel_n = 1'b0;
    idle(1); rd_n = 1'b0; idle(30);
    rd_n = 1'b1; idle(1); sel_n = 1'b1; idle(4);
    chk("R12 long read pops once", n_pop - pops, 1);
    @(negedge clk); addr = 3'd6; sel_n = 1'b0;
    idle(1); rd_n = 1'b0; idle(6);
    cts_n = 1'b0; idle(8);
    rd_n = 1'b1; idle(1); sel_n = 1'b1; idle(4);
    reg_read(3'd6, v); chk("R12 change during held read kept", int'(v), 'h11);
    cts_n = 1'b1; idle(6);
    reg_read(3'd6, v);
  endtask

  task automatic t_unselected();
    logic [7:0] v;
    @(negedge clk); addr = 3'd3; din = 8'h00; sel_n = 1'b1;
    idle(1); wr_n = 1'b0; idle(4); wr_n = 1'b1; idle(4);
    rd_n = 1'b0; idle(5);
    chk("R13 no enable unselected", int'(dout_en), 0);
    rd_n = 1'b1; idle(4);
    reg_read(3'd3, v); chk("R13 lcr unchanged", int'(v), 'h3B);
  endtask

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = '0; din = '0;
    rx_data = '0; rx_ready = 1'b0; rx_trig = 1'b0; rx_tmo = 1'b0;
    err_overrun = 1'b0; err_parity = 1'b0; err_framing = 1'b0; err_break = 1'b0;
    thr_empty = 1'b0; tx_idle = 1'b0;
    cts_n = 1'b1; dsr_n = 1'b1; ri_n = 1'b1; dcd_n = 1'b1;
    idle(4); rst_n = 1'b1; idle(6);
    t_reset();
    t_bank();
    t_fifo_mcr();
    t_lsr();
    t_prio();
    t_thre();
    t_modem();
    t_once();
    t_unselected();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule